// File: doc/BRIEF.md
# DRAM Wake-Up and Test-Mode Strobe Sequencer

This block sits on the controller side of an asynchronous DRAM and owns the row strobe, column strobe, write enable and output enable lines. It does not run until the host pulses `start_i`. It then keeps every strobe inactive for a start-up hold-off. After that it runs a fixed number of CAS-before-RAS refresh cycles to wake the array, and only then raises `ready_o`. All intervals are set in microseconds or nanoseconds. Each one is turned into whole clock cycles from the `CLK_MHZ` parameter, and any fraction rounds up.

Once the block is ready, the host can send it into the DRAM's parallel test mode. The block does this with a CAS-before-RAS cycle in which write enable stays asserted. The host takes it back out with a RAS-only refresh. A flag register follows the mode. The access-wait count offered to the read path grows by 5 ns, rounded up to whole cycles, while the flag is set.

The states are:
- `ST_OFF`: after reset.
- `ST_WAIT`: the start-up hold-off.
- `ST_IDLE`: ready.
- `ST_CBR_SU`: CAS only, the setup phase.
- `ST_CBR_LO`: RAS and CAS both asserted.
- `ST_CBR_HD`: RAS released, CAS still held.
- `ST_ROR_LO`: RAS only.
- `ST_PRE`: all strobes released, precharge.

The transitions are:
- OFF→WAIT on start.
- IDLE→WAIT on start.
- IDLE→CBR_SU on enter.
- IDLE→ROR_LO on exit.
- WAIT→CBR_SU when the hold-off expires.
- CBR_SU→CBR_LO→CBR_HD→PRE as each phase count expires.
- ROR_LO→PRE when its phase count expires.
- PRE→CBR_SU while wake-up cycles remain.
- PRE→IDLE otherwise.

Top module: `dram_wake_seq`

## Requirements
- R1: After `start_i` is accepted, all strobes stay high with `busy_o`=1 and `ready_o`=0 for exactly STARTUP_US*CLK_MHZ cycles.
- R2: Each wake-up cycle is a CAS-before-RAS refresh with `we_n_o` high, made of four phases with these widths in cycles:
  - CAS alone for ceil(T_CSR_NS*CLK_MHZ/1000);
  - RAS and CAS together for ceil(T_RAS_NS*CLK_MHZ/1000);
  - CAS alone for ceil(T_CHR_NS*CLK_MHZ/1000);
  - all strobes high for ceil(T_RP_NS*CLK_MHZ/1000).
- R3: Exactly INIT_CYCLES such cycles run. In the cycle that follows the last precharge, `ready_o`=1 and `busy_o`=0. `ready_o` and `busy_o` are never both 1.
- R4: `enter_test_i` in ready runs the same four-phase CBR cycle with `we_n_o` low during the three CAS-asserted phases. `test_mode_o` becomes 1 in the cycle in which `ready_o` returns.
- R5: `exit_test_i` in ready runs a RAS-only refresh, with RAS low for the RAS width and CAS and WE high, followed by precharge. `test_mode_o` becomes 0 when `ready_o` returns.
- R6: `rd_wait_o` equals ceil(T_ACC_NS*CLK_MHZ/1000) while test mode is off. It equals ceil((T_ACC_NS+T_TEST_EXTRA_NS)*CLK_MHZ/1000) while test mode is on.
- R7: Commands that arrive while `busy_o`=1 are ignored. The strobe sequence in progress runs unaltered and `test_mode_o` does not change.
- R8: When commands coincide, start wins over enter and enter wins over exit. In `ST_OFF` only start is acted on.
- R9: After reset all strobes are high, and `busy_o`, `ready_o` and `test_mode_o` are 0.
- R10: `oe_n_o` stays high in every state.
- R11: `start_i` in ready reruns the full wake-up. Its plain CBR cycles leave `test_mode_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin (or rerun) the wake-up sequence |
| enter_test_i | input | 1 | Request entry into parallel test mode |
| exit_test_i | input | 1 | Request exit from parallel test mode |
| busy_o | output | 1 | A sequence is running; commands are ignored |
| ready_o | output | 1 | Wake-up done, DRAM available |
| test_mode_o | output | 1 | Test-mode flag |
| rd_wait_o | output | WAIT_W | Read access wait in clock cycles |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| oe_n_o | output | 1 | Output enable, active low |

## Verification
Two sets of collisions can land in one clock edge.

The first is several host commands at once. The bench sweeps all eight combinations of start, enter and exit from ready, in both test-mode states. It judges each one by which strobe sequence follows and by the resulting flag.

The second is a command that arrives while a sequence is running. The bench pokes enter, exit and start during the hold-off and during a wake-up refresh. These pokes are judged correct only if every phase still keeps its computed width and the flag is unchanged.

// File: rtl/wk_pkg.sv
package wk_pkg;

    typedef enum logic [2:0] {
        ST_OFF, ST_WAIT, ST_IDLE, ST_CBR_SU,
        ST_CBR_LO, ST_CBR_HD, ST_ROR_LO, ST_PRE
    } wk_state_e;

    typedef enum logic [1:0] {
        OP_INIT, OP_ENTER, OP_EXIT
    } wk_op_e;

    // nanoseconds to clock cycles, rounded up, never below one
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned mhz);
        int unsigned c;
        c = (ns * mhz + 999) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/wk_down_cnt.sv
module wk_down_cnt #(
    parameter int W    = 16,
    parameter bit AUTO = 1'b1   // 1: count every cycle, 0: count on dec_i
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic [W-1:0] cnt_o
);

    logic [W-1:0] cnt_q;
    logic         step;

    generate
        if (AUTO) begin : g_auto
            assign step = (cnt_q != '0);
        end else begin : g_manual
            assign step = dec_i;
            // R3: the wake-up counter is never stepped past zero
            assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
                !(dec_i && !load_i && cnt_q == '0));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load_i) cnt_q <= load_val_i;
        else if (step)   cnt_q <= cnt_q - 1'b1;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/wk_strobe_dec.sv
module wk_strobe_dec
    import wk_pkg::*;
(
    input  wk_state_e state_i,
    input  wk_op_e    op_i,
    output logic      ras_n_o,
    output logic      cas_n_o,
    output logic      we_n_o,
    output logic      oe_n_o
);

    logic cas_phase;

    always_comb begin
        ras_n_o   = 1'b1;
        cas_n_o   = 1'b1;
        oe_n_o    = 1'b1;
        cas_phase = 1'b0;
        unique case (state_i)
            ST_CBR_SU: begin cas_n_o = 1'b0; cas_phase = 1'b1; end
            ST_CBR_LO: begin cas_n_o = 1'b0; ras_n_o = 1'b0; cas_phase = 1'b1; end
            ST_CBR_HD: begin cas_n_o = 1'b0; cas_phase = 1'b1; end
            ST_ROR_LO: ras_n_o = 1'b0;
            default:   ;
        endcase
        we_n_o = !(cas_phase && op_i == OP_ENTER);
    end

endmodule

// File: rtl/dram_wake_seq.sv
module dram_wake_seq
    import wk_pkg::*;
#(
    parameter int CLK_MHZ         = 100,
    parameter int STARTUP_US      = 200,
    parameter int INIT_CYCLES     = 8,
    parameter int T_CSR_NS        = 10,
    parameter int T_RAS_NS        = 60,
    parameter int T_CHR_NS        = 15,
    parameter int T_RP_NS         = 40,
    parameter int T_ACC_NS        = 60,
    parameter int T_TEST_EXTRA_NS = 5,
    parameter int WAIT_W          = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              enter_test_i,
    input  logic              exit_test_i,
    output logic              busy_o,
    output logic              ready_o,
    output logic              test_mode_o,
    output logic [WAIT_W-1:0] rd_wait_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic              oe_n_o
);

    localparam int CYC_START = STARTUP_US * CLK_MHZ;
    localparam int CYC_CSR   = ns_to_cyc(T_CSR_NS, CLK_MHZ);
    localparam int CYC_RAS   = ns_to_cyc(T_RAS_NS, CLK_MHZ);
    localparam int CYC_CHR   = ns_to_cyc(T_CHR_NS, CLK_MHZ);
    localparam int CYC_RP    = ns_to_cyc(T_RP_NS, CLK_MHZ);
    localparam int CYC_ACC_N = ns_to_cyc(T_ACC_NS, CLK_MHZ);
    localparam int CYC_ACC_T = ns_to_cyc(T_ACC_NS + T_TEST_EXTRA_NS, CLK_MHZ);
    localparam int MAX_PH    = (CYC_RAS > CYC_RP) ? CYC_RAS : CYC_RP;
    localparam int MAX_ALL   = (CYC_START > MAX_PH) ? CYC_START : MAX_PH;
    localparam int TMR_W     = $clog2(MAX_ALL + 1);
    localparam int INI_W     = $clog2(INIT_CYCLES + 1);

    localparam logic [TMR_W-1:0] LD_START = TMR_W'(CYC_START - 1);
    localparam logic [TMR_W-1:0] LD_CSR   = TMR_W'(CYC_CSR - 1);
    localparam logic [TMR_W-1:0] LD_RAS   = TMR_W'(CYC_RAS - 1);
    localparam logic [TMR_W-1:0] LD_CHR   = TMR_W'(CYC_CHR - 1);
    localparam logic [TMR_W-1:0] LD_RP    = TMR_W'(CYC_RP - 1);

    wk_state_e        state_q, state_d;
    wk_op_e           op_q, op_d;
    logic             test_q, test_d;
    logic             tmr_load, ini_load, ini_dec;
    logic [TMR_W-1:0] tmr_val, tmr_cnt;
    logic [INI_W-1:0] ini_cnt;
    logic             tmr_zero, ini_last;

    assign tmr_zero = (tmr_cnt == '0);
    assign ini_last = (ini_cnt == INI_W'(1));

    wk_down_cnt #(.W(TMR_W), .AUTO(1'b1)) u_phase_tmr (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val),
        .dec_i(1'b0), .cnt_o(tmr_cnt)
    );

    wk_down_cnt #(.W(INI_W), .AUTO(1'b0)) u_init_cnt (
        .clk(clk), .rst_n(rst_n), .load_i(ini_load),
        .load_val_i(INI_W'(INIT_CYCLES)), .dec_i(ini_dec), .cnt_o(ini_cnt)
    );

    // next-state and sequencing
    always_comb begin
        state_d  = state_q;
        op_d     = op_q;
        test_d   = test_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ini_load = 1'b0;
        ini_dec  = 1'b0;
        unique case (state_q)
            ST_OFF, ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_WAIT; op_d = OP_INIT;
                    tmr_load = 1'b1; tmr_val = LD_START; ini_load = 1'b1;
                end else if (state_q == ST_IDLE && enter_test_i) begin
                    state_d = ST_CBR_SU; op_d = OP_ENTER;
                    tmr_load = 1'b1; tmr_val = LD_CSR;
                end else if (state_q == ST_IDLE && exit_test_i) begin
                    state_d = ST_ROR_LO; op_d = OP_EXIT;
                    tmr_load = 1'b1; tmr_val = LD_RAS;
                end
            end
            ST_WAIT: if (tmr_zero) begin
                state_d = ST_CBR_SU; tmr_load = 1'b1; tmr_val = LD_CSR;
            end
            ST_CBR_SU: if (tmr_zero) begin
                state_d = ST_CBR_LO; tmr_load = 1'b1; tmr_val = LD_RAS;
            end
            ST_CBR_LO: if (tmr_zero) begin
                state_d = ST_CBR_HD; tmr_load = 1'b1; tmr_val = LD_CHR;
            end
            ST_CBR_HD, ST_ROR_LO: if (tmr_zero) begin
                state_d = ST_PRE; tmr_load = 1'b1; tmr_val = LD_RP;
            end
            ST_PRE: if (tmr_zero) begin
                if (op_q == OP_INIT && !ini_last) begin
                    state_d = ST_CBR_SU; tmr_load = 1'b1; tmr_val = LD_CSR;
                    ini_dec = 1'b1;
                end else begin
                    state_d = ST_IDLE;
                    test_d  = (op_q == OP_ENTER);
                    ini_dec = (op_q == OP_INIT);
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            op_q    <= OP_INIT;
            test_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
            test_q  <= test_d;
        end
    end

    wk_strobe_dec u_strobes (
        .state_i(state_q), .op_i(op_q),
        .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o), .oe_n_o(oe_n_o)
    );

    // host-side outputs
    always_comb begin
        ready_o     = (state_q == ST_IDLE);
        busy_o      = (state_q != ST_IDLE) && (state_q != ST_OFF);
        test_mode_o = test_q;
        rd_wait_o   = test_q ? WAIT_W'(CYC_ACC_T) : WAIT_W'(CYC_ACC_N);
    end

    assert_cas_before_ras_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n_o) && !cas_n_o) |-> $past(!cas_n_o));
    assert_ras_released_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n_o) |-> (ras_n_o && $past(ras_n_o)));
    assert_ready_busy_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready_o && busy_o));
    assert_we_inside_cas_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_o |-> !cas_n_o);
    assert_flag_moves_at_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(test_mode_o) |-> ready_o);
    assert_busy_holds_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(test_mode_o));

endmodule

// File: tb/dram_wake_seq_bench.sv
module dram_wake_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MHZ  = 50;
    localparam int SUS  = 2;
    localparam int NINI = 3;

    function automatic int cyc(int ns);
        int c;
        c = (ns * MHZ + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int E_START = SUS * MHZ;
    localparam int E_CSR   = (10 * MHZ + 999) / 1000;
    localparam int E_RAS   = (60 * MHZ + 999) / 1000;
    localparam int E_CHR   = (15 * MHZ + 999) / 1000;
    localparam int E_RP    = (40 * MHZ + 999) / 1000;

    // {ras_n, cas_n, we_n, oe_n, busy, ready}
    localparam logic [5:0] P_OFF  = 6'b1111_00;
    localparam logic [5:0] P_HOLD = 6'b1111_10;
    localparam logic [5:0] P_IDLE = 6'b1111_01;
    localparam logic [5:0] P_CAS  = 6'b1011_10;
    localparam logic [5:0] P_BOTH = 6'b0011_10;
    localparam logic [5:0] P_CASW = 6'b1001_10;
    localparam logic [5:0] P_BOTW = 6'b0001_10;
    localparam logic [5:0] P_RAS  = 6'b0111_10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 1'b0, enter_test_i = 1'b0, exit_test_i = 1'b0;
    logic busy_o, ready_o, test_mode_o, ras_n_o, cas_n_o, we_n_o, oe_n_o;
    logic [7:0] rd_wait_o;
    int checks = 0, failures = 0;
    bit tm = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_wake_seq #(.CLK_MHZ(MHZ), .STARTUP_US(SUS), .INIT_CYCLES(NINI)) u_dram_wake_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .enter_test_i(enter_test_i),
        .exit_test_i(exit_test_i), .busy_o(busy_o), .ready_o(ready_o),
        .test_mode_o(test_mode_o), .rd_wait_o(rd_wait_o), .ras_n_o(ras_n_o),
        .cas_n_o(cas_n_o), .we_n_o(we_n_o), .oe_n_o(oe_n_o)
    );

    function automatic logic [5:0] vec();
        return {ras_n_o, cas_n_o, we_n_o, oe_n_o, busy_o, ready_o};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // pattern must hold for exactly len samples, one per falling edge
    task automatic phase(input string req, input logic [5:0] pat, input int len);
        logic [5:0] bad;
        bit ok;
        ok = 1'b1;
        bad = pat;
        for (int i = 0; i < len; i++) begin
            if (vec() !== pat && ok) begin ok = 1'b0; bad = vec(); end
            @(negedge clk);
        end
        check(req, 32'(bad), 32'(pat));
    endtask

    task automatic cmd(input bit s, input bit e, input bit x);
        start_i = s; enter_test_i = e; exit_test_i = x;
        @(negedge clk);
        start_i = 1'b0; enter_test_i = 1'b0; exit_test_i = 1'b0;
    endtask

    task automatic cbr(input string req, input bit we);
        phase(req, we ? P_CASW : P_CAS, E_CSR);
        phase(req, we ? P_BOTW : P_BOTH, E_RAS);
        phase(req, we ? P_CASW : P_CAS, E_CHR);
        phase(req, P_HOLD, E_RP);
    endtask

    task automatic wakeup();
        phase("R1 hold-off", P_HOLD, E_START);
        for (int k = 0; k < NINI; k++) cbr("R2 wake refresh", 1'b0);
    endtask

    task automatic poke_busy();
        repeat (30) @(negedge clk);
        enter_test_i = 1'b1; @(negedge clk); enter_test_i = 1'b0;
        repeat (29) @(negedge clk);
        exit_test_i = 1'b1; @(negedge clk); exit_test_i = 1'b0;
        repeat (44) @(negedge clk);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    endtask

    task automatic check_idle(input string req);
        check(req, 32'(vec()), 32'(P_IDLE));
        check({req, " flag"}, 32'(test_mode_o), 32'(tm));
        check("R6 rd_wait", 32'(rd_wait_o), 32'(tm ? cyc(65) : cyc(60)));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R9 reset strobes", 32'(vec()), 32'(P_OFF));
        check("R9 reset flag", 32'(test_mode_o), 32'd0);
        check("R6 rd_wait normal", 32'(rd_wait_o), 32'(cyc(60)));
        rst_n = 1'b1;
        @(negedge clk);
        // R8: enter/exit in OFF do nothing
        cmd(1'b0, 1'b1, 1'b1);
        phase("R8 off ignores test cmds", P_OFF, 5);
        // R8 start beats enter; R7 pokes during the sequence are ignored
        cmd(1'b1, 1'b1, 1'b0);
        fork
            wakeup();
            poke_busy();
        join
        check_idle("R3 ready after wake-up");
        // sweep all command combinations from ready, twice so both flag states precede each
        for (int pass = 0; pass < 2; pass++) begin
            for (int c = 0; c < 8; c++) begin
                bit s, e, x;
                s = c[2]; e = c[1]; x = c[0];
                if (pass == 1) begin
                    cmd(1'b0, 1'b1, 1'b0);  // R4 force flag on before each combo
                    cbr("R4 pre-enter", 1'b1);
                    tm = 1'b1;
                end
                cmd(s, e, x);
                if (s) begin
                    wakeup();
                    tm = 1'b0;
                    check_idle("R11 rerun clears flag");
                end else if (e) begin
                    cbr("R4 enter cycle", 1'b1);
                    tm = 1'b1;
                    check_idle("R4 enter sets flag");
                end else if (x) begin
                    phase("R5 ras-only", P_RAS, E_RAS);
                    phase("R5 precharge", P_HOLD, E_RP);
                    tm = 1'b0;
                    check_idle("R5 exit clears flag");
                end else begin
                    phase("R8 no command", P_IDLE, 3);
                    check_idle("R8 no command");
                end
                check("R10 oe high", 32'(oe_n_o), 32'd1);
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule